// File: doc/BRIEF.md
# Linked-List Transfer Descriptor Fetcher

This block serves one transfer channel that runs in linked-list mode. When the channel asks for a descriptor, the block reads four consecutive words from memory, starting at a base address the channel supplies. It uses a simple word-read master port with a valid/ready address handshake and a separate response strobe, and only one read is outstanding at a time. From those four words it builds the channel's new working register values and presents them together with a one-cycle completion strobe.

Word 0 of a descriptor is its control word. Word 1 is the source address, word 2 the destination address and word 3 the pointer to the next descriptor. From the control word, four mode flags are copied into the channel control word and a total-size field is copied into the channel size register. The block also reports whether the chain continues after this descriptor. It keeps the address of the descriptor just read as the current descriptor, and it returns the fetched next pointer as the channel's new descriptor pointer. It does not move data and does not write anything back.

Top module: `desc_fetch`

## Requirements
- R1: While reset is asserted, every output is zero. This includes `rd_valid`, `busy` and `done`.
- R2: After an accepted request, exactly four reads are issued, one at a time, at base+0x0, base+0x4, base+0x8 and base+0xC, in that order. `rd_valid` stays high with a stable `rd_addr` until `rd_ready`. No new address is offered while a read response is still pending.
- R3: `busy` is high from the cycle after an accepted request until the fourth word has been committed. `done` is high for exactly one cycle, in the cycle after the commit, and it never stays high for two cycles.
- R4: `ch_ctrl_o` equals the `ch_ctrl_i` sampled at the request, with bit 3 (source increment), bit 4 (destination increment), bit 5 (source select) and bit 6 (destination select) replaced by control-word bits 17, 18, 19 and 20 respectively. All other bits are unchanged.
- R5: `ch_size_o` equals the sampled `ch_size_i`, with its low TSZ_W bits (total size, 12 by default) replaced by control-word bits [TSZ_W-1:0]. The upper bits, which hold the chunk size, are unchanged.
- R6: `src_addr_o` equals word 1 and `dst_addr_o` equals word 2 of the descriptor.
- R7: `cur_desc_o` equals the base address of the descriptor just fetched, and `next_ptr_o` equals word 3.
- R8: `more_o` is the inverse of control-word bit 16, the end-of-list flag. A value of 1 means another descriptor follows.
- R9: A request raised while `busy` is high is ignored. The reads, their addresses and the results stay those of the request already in progress.
- R10: All result outputs hold their values in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Request to fetch one descriptor |
| desc_base | input | AW | Descriptor base address, sampled on an accepted request |
| ch_ctrl_i | input | CW | Current channel control word, sampled on an accepted request |
| ch_size_i | input | CW | Current channel size register, sampled on an accepted request |
| rd_valid | output | 1 | Read address valid |
| rd_addr | output | AW | Read word address |
| rd_ready | input | 1 | Read address accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | AW | Read data |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion strobe |
| ch_ctrl_o | output | CW | Updated channel control word |
| ch_size_o | output | CW | Updated channel size register |
| src_addr_o | output | AW | New source address |
| dst_addr_o | output | AW | New destination address |
| next_ptr_o | output | AW | New descriptor pointer (next in chain) |
| cur_desc_o | output | AW | Address of the descriptor just fetched |
| more_o | output | 1 | Chain continues after this descriptor |

## Verification
A second request can arrive in the same cycle as an address handshake or a read response of the fetch already running. Only an ignore rule keeps the two apart. The bench provokes this by raising a request with a different base and different channel words while the memory model is accepting or answering a read. It then judges the overlap by checking that the recorded read addresses still follow the first base. It also checks that every result matches the values expected from the first request's inputs. The memory model randomises address acceptance and response latency, so these overlaps land in different phases of the fetch.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;

  localparam int unsigned NWORDS   = 4;
  localparam int unsigned IDX_W    = 2;

  // descriptor word order (offset = index * 4)
  localparam logic [IDX_W-1:0] W_CTRL = 2'd0;
  localparam logic [IDX_W-1:0] W_SRC  = 2'd1;
  localparam logic [IDX_W-1:0] W_DST  = 2'd2;
  localparam logic [IDX_W-1:0] W_NEXT = 2'd3;

  // descriptor control word fields
  localparam int unsigned DC_LAST     = 16;
  localparam int unsigned DC_FLAG_LSB = 17;

  // channel control word flag field
  localparam int unsigned CH_FLAG_LSB = 3;
  localparam int unsigned NFLAGS      = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_COMMIT = 2'd3
  } fetch_state_e;

endpackage

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
  import desc_fetch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rd_ready_i,
  input  logic             rsp_valid_i,
  output logic             accept_o,
  output logic             rd_valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             cap_en_o,
  output logic             commit_o,
  output logic             busy_o
);

  fetch_state_e     state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    accept_o = 1'b0;
    cap_en_o = 1'b0;
    commit_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          idx_d    = W_CTRL;
          idx_en   = 1'b1;
          state_d  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (rd_ready_i) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (rsp_valid_i) begin
          cap_en_o = 1'b1;
          if (idx_q == W_NEXT) begin
            state_d = ST_COMMIT;
          end else begin
            idx_d   = idx_q + 1'b1;
            idx_en  = 1'b1;
            state_d = ST_ADDR;
          end
        end
      end
      ST_COMMIT: begin
        commit_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign rd_valid_o = (state_q == ST_ADDR);
  assign busy_o     = (state_q != ST_IDLE);
  assign idx_o      = idx_q;

endmodule

// File: rtl/desc_word_store.sv
module desc_word_store
  import desc_fetch_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    words_o [NWORDS]
);

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic          wr_en;
    logic [DW-1:0] word_q;

    assign wr_en = cap_en_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_en) begin
        word_q <= data_i;
      end
    end

    assign words_o[g] = word_q;
  end

endmodule

// File: rtl/desc_merge.sv
module desc_merge
  import desc_fetch_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 32,
  parameter int unsigned TSZ_W = 12
) (
  input  logic [DW-1:0] dctrl_i,
  input  logic [CW-1:0] ch_ctrl_i,
  input  logic [CW-1:0] ch_size_i,
  output logic [CW-1:0] ch_ctrl_o,
  output logic [CW-1:0] ch_size_o,
  output logic          more_o
);

  localparam logic [CW-1:0] FLAG_MASK = CW'({NFLAGS{1'b1}}) << CH_FLAG_LSB;
  localparam logic [CW-1:0] TSZ_MASK  = CW'({TSZ_W{1'b1}});

  logic [NFLAGS-1:0] flags;
  logic [TSZ_W-1:0]  tot_sz;

  always_comb begin
    flags     = dctrl_i[DC_FLAG_LSB +: NFLAGS];
    tot_sz    = dctrl_i[TSZ_W-1:0];
    ch_ctrl_o = (ch_ctrl_i & ~FLAG_MASK) | (CW'(flags) << CH_FLAG_LSB);
    ch_size_o = (ch_size_i & ~TSZ_MASK) | CW'(tot_sz);
    more_o    = ~dctrl_i[DC_LAST];
  end

endmodule

// File: rtl/desc_fetch.sv
module desc_fetch
  import desc_fetch_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 32,
  parameter int unsigned TSZ_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] desc_base,
  input  logic [CW-1:0] ch_ctrl_i,
  input  logic [CW-1:0] ch_size_i,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] ch_ctrl_o,
  output logic [CW-1:0] ch_size_o,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic [AW-1:0] next_ptr_o,
  output logic [AW-1:0] cur_desc_o,
  output logic          more_o
);

  localparam int unsigned BYTE_SH = 2;

  logic             accept, cap_en, commit;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    words [NWORDS];
  logic [AW-1:0]    base_q;
  logic [CW-1:0]    ctrl_in_q, size_in_q;
  logic [CW-1:0]    ctrl_new, size_new;
  logic             more_new;

  desc_fetch_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (fetch_req),
    .rd_ready_i (rd_ready),
    .rsp_valid_i(rsp_valid),
    .accept_o   (accept),
    .rd_valid_o (rd_valid),
    .idx_o      (idx),
    .cap_en_o   (cap_en),
    .commit_o   (commit),
    .busy_o     (busy)
  );

  desc_word_store #(.DW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en_i(cap_en),
    .idx_i   (idx),
    .data_i  (rsp_data),
    .words_o (words)
  );

  desc_merge #(.DW(AW), .CW(CW), .TSZ_W(TSZ_W)) u_merge (
    .dctrl_i  (words[W_CTRL]),
    .ch_ctrl_i(ctrl_in_q),
    .ch_size_i(size_in_q),
    .ch_ctrl_o(ctrl_new),
    .ch_size_o(size_new),
    .more_o   (more_new)
  );

  // request snapshot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      ctrl_in_q <= '0;
      size_in_q <= '0;
    end else if (accept) begin
      base_q    <= desc_base;
      ctrl_in_q <= ch_ctrl_i;
      size_in_q <= ch_size_i;
    end
  end

  assign rd_addr = base_q + (AW'(idx) << BYTE_SH);

  // result registers, loaded together with the completion strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      ch_ctrl_o  <= '0;
      ch_size_o  <= '0;
      src_addr_o <= '0;
      dst_addr_o <= '0;
      next_ptr_o <= '0;
      cur_desc_o <= '0;
      more_o     <= 1'b0;
    end else begin
      done <= commit;
      if (commit) begin
        ch_ctrl_o  <= ctrl_new;
        ch_size_o  <= size_new;
        src_addr_o <= words[W_SRC];
        dst_addr_o <= words[W_DST];
        next_ptr_o <= words[W_NEXT];
        cur_desc_o <= base_q;
        more_o     <= more_new;
      end
    end
  end

endmodule

// File: rtl/desc_fetch_chk.sv
module desc_fetch_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ready,
  input logic          rsp_valid,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] ch_ctrl_o,
  input logic [CW-1:0] ch_size_o,
  input logic [AW-1:0] src_addr_o,
  input logic [AW-1:0] dst_addr_o,
  input logic [AW-1:0] next_ptr_o,
  input logic [AW-1:0] cur_desc_o
);

  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else if (rd_valid && rd_ready) pending_q <= 1'b1;
    else if (rsp_valid) pending_q <= 1'b0;
  end

  p_valid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !rd_valid);

  p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[1:0] == 2'b00);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_valid && !pending_q);

  p_hold_results_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ch_ctrl_o) && $stable(ch_size_o) && $stable(src_addr_o)
              && $stable(dst_addr_o) && $stable(next_ptr_o) && $stable(cur_desc_o));

  p_busy_covers_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

endmodule

bind desc_fetch desc_fetch_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid),
  .rd_addr   (rd_addr),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid),
  .busy      (busy),
  .done      (done),
  .ch_ctrl_o (ch_ctrl_o),
  .ch_size_o (ch_size_o),
  .src_addr_o(src_addr_o),
  .dst_addr_o(dst_addr_o),
  .next_ptr_o(next_ptr_o),
  .cur_desc_o(cur_desc_o)
);

// File: tb/desc_fetch_tb.sv
module desc_fetch_tb;

  localparam int AW = 32;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_req;
  logic [AW-1:0] desc_base;
  logic [CW-1:0] ch_ctrl_i, ch_size_i;
  logic          rd_valid, rd_ready, rsp_valid;
  logic [AW-1:0] rd_addr, rsp_data;
  logic          busy, done, more_o;
  logic [CW-1:0] ch_ctrl_o, ch_size_o;
  logic [AW-1:0] src_addr_o, dst_addr_o, next_ptr_o, cur_desc_o;

  int n_chk = 0;
  int n_bad = 0;

  // memory model state
  logic          pend;
  logic [AW-1:0] pend_addr;
  int            pend_dly;
  logic [AW-1:0] rec_addr [8];
  int            n_rec;
  logic          ovr_en;
  logic [AW-1:0] ovr_base, ovr_word;
  logic          mem_on;

  always #5 clk = ~clk;

  desc_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .desc_base(desc_base),
    .ch_ctrl_i(ch_ctrl_i), .ch_size_i(ch_size_i), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .done(done), .ch_ctrl_o(ch_ctrl_o),
    .ch_size_o(ch_size_o), .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
    .next_ptr_o(next_ptr_o), .cur_desc_o(cur_desc_o), .more_o(more_o)
  );

  function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
    if (ovr_en && a == ovr_base) return ovr_word;
    return (a * 32'h9E37_79B1) ^ (a >> 7) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [CW-1:0] exp_ctrl(input logic [CW-1:0] c, input logic [AW-1:0] w);
    return (c & ~32'h0000_0078) | (((w >> 17) & 32'hF) << 3);
  endfunction

  function automatic logic [CW-1:0] exp_size(input logic [CW-1:0] s, input logic [AW-1:0] w);
    return (s & ~32'h0000_0FFF) | (w & 32'h0000_0FFF);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: decisions at the falling edge
  initial begin
    rd_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    pend = 1'b0; pend_addr = '0; pend_dly = 0; n_rec = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend) begin
        if (pend_dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mem_word(pend_addr);
          pend      = 1'b0;
        end else pend_dly--;
      end
      rd_ready = mem_on && (($urandom % 3) != 0);
      if (rd_valid && pend) check("R2 overlap", 1, 0);
      if (rd_valid && rd_ready && !pend) begin
        pend      = 1'b1;
        pend_addr = rd_addr;
        pend_dly  = $urandom % 3;
        if (n_rec < 8) rec_addr[n_rec] = rd_addr;
        n_rec++;
      end
    end
  end

  task automatic run_fetch(input logic [AW-1:0] base, input logic [CW-1:0] c,
                           input logic [CW-1:0] s, input bit intrude);
    int t;
    logic [AW-1:0] w0;
    n_rec = 0;
    @(negedge clk);
    fetch_req = 1'b1; desc_base = base; ch_ctrl_i = c; ch_size_i = s;
    @(negedge clk);
    fetch_req = 1'b0;
    check("R3 busy after request", {63'd0, busy}, 64'd1);
    t = 0;
    while (!done && t < 100) begin
      if (intrude && t == 2) begin
        fetch_req = 1'b1; desc_base = base ^ 32'h0000_4000;
        ch_ctrl_i = ~c; ch_size_i = ~s;
      end else fetch_req = 1'b0;
      @(negedge clk);
      t++;
    end
    fetch_req = 1'b0;
    check("R3 done reached", {63'd0, done}, 64'd1);
    check("R3 not busy at done", {63'd0, busy}, 64'd0);
    check("R2 read count", 64'(n_rec), 64'd4);
    for (int i = 0; i < 4; i++) check("R2 R9 read address", 64'(rec_addr[i]), 64'(base + 32'(4 * i)));
    w0 = mem_word(base);
    check("R4 ctrl flags", 64'(ch_ctrl_o), 64'(exp_ctrl(c, w0)));
    check("R5 size field", 64'(ch_size_o), 64'(exp_size(s, w0)));
    check("R6 src", 64'(src_addr_o), 64'(mem_word(base + 4)));
    check("R6 dst", 64'(dst_addr_o), 64'(mem_word(base + 8)));
    check("R7 next", 64'(next_ptr_o), 64'(mem_word(base + 12)));
    check("R7 cur", 64'(cur_desc_o), 64'(base));
    check("R8 more", {63'd0, more_o}, {63'd0, ~w0[16]});
    @(negedge clk);
    check("R3 done one cycle", {63'd0, done}, 64'd0);
    check("R10 hold src", 64'(src_addr_o), 64'(mem_word(base + 4)));
    check("R10 hold ctrl", 64'(ch_ctrl_o), 64'(exp_ctrl(c, w0)));
  endtask

  initial begin
    logic [AW-1:0] b;
    void'($urandom(32'd12345));
    rst_n = 1'b0; fetch_req = 1'b0; desc_base = '0; ch_ctrl_i = '0; ch_size_i = '0;
    ovr_en = 1'b0; ovr_base = '0; ovr_word = '0; mem_on = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", {63'd0, rd_valid}, 0);
    check("R1 busy", {63'd0, busy}, 0);
    check("R1 done", {63'd0, done}, 0);
    check("R1 ctrl", 64'(ch_ctrl_o), 0);
    check("R1 next", 64'(next_ptr_o), 0);
    check("R1 more", {63'd0, more_o}, 0);
    rst_n = 1'b1; mem_on = 1'b1;
    // directed: all flags set, end of list, all-ones size field
    ovr_en = 1'b1; ovr_base = 32'h0000_1000; ovr_word = 32'h001F_0FFF;
    run_fetch(32'h0000_1000, 32'h0000_0000, 32'h0123_4000, 1'b0);
    // directed: no flags, list continues, zero size, channel bits all ones
    ovr_base = 32'h0000_2000; ovr_word = 32'h0000_0000;
    run_fetch(32'h0000_2000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    ovr_en = 1'b0;
    // R9: intruding request during a fetch
    run_fetch(32'h0000_3000, 32'h0000_0081, 32'h0010_0020, 1'b1);
    // random fetches, some walking the returned pointer
    b = 32'h0000_8000;
    for (int k = 0; k < 40; k++) begin
      run_fetch(b, $urandom, $urandom, (k % 4) == 1);
      if (more_o && (k % 2 == 0)) b = next_ptr_o & 32'h00FF_FFF0;
      else b = $urandom & 32'h00FF_FFF0;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule